// File: doc/BRIEF.md
# UART Receive DMA Engine with Error Interrupt

This block sits between a UART receiver and system memory. Each character the receiver hands over is collected into a packing register. Once enough characters have arrived to fill the selected transfer size (one, two or four bytes), the block issues a single memory write. The write address then advances by that size, and a transfer counter counts down. When the last programmed write has been issued, the engine stops and flags completion.

A single receive interrupt covers two causes. The first is block completion. The second is a receive line error (overrun, parity or framing), which raises the interrupt only when error interrupts are enabled. The line error is recorded in two places. The first is a UART-side error flag set, which a line-status read reports and clears. The second is an engine-side status bit, which is cleared only by writing 1 to it. The interrupt stays high until every flag behind it has been cleared.

The configuration word `cfg_ctl` uses these bits: bit 0 is enable, bit 1 is direction (1 means toward memory), bits [3:2] are the size code, and bit 4 is error-interrupt enable. The status word `irq_stat` has bit 0 for completion and bit 1 for the engine-side line error. Line flags in `rx_err` and `lsr_data` are ordered as bit 0 overrun, bit 1 parity, bit 2 framing.

Top module: `uart_rxdma_ctrl`

## Requirements
- R1: The size code 2'b11 writes every byte, 2'b00 writes every 2 bytes and 2'b01 writes every 4 bytes. Bytes are packed little-endian and zero-extended in `mem_wdata`, and the address advances by 1, 2 or 4 after each write.
- R2: `mem_we` is a one-cycle pulse in the clock after the byte that completes a word, and it carries the address and data of that word.
- R3: A configuration write starts a transfer (`dma_active` high) only when enable and direction are both 1 and the count is nonzero. Otherwise no memory write occurs.
- R4: With the reserved size code 2'b10 the engine does not start, and received bytes produce no memory write.
- R5: After the programmed number of writes, `dma_active` falls and `irq_stat[0]` rises in the same cycle as the last `mem_we`. Bytes received afterwards cause no write.
- R6: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R7: With error interrupts enabled, a byte flagged with any line error sets `irq_stat[1]` and the UART-side request, and `rx_irq` rises one cycle later.
- R8: A byte received with a line error is still stored, and the transfer continues.
- R9: `lsr_data` holds the sticky line-error flags. A pulse on `lsr_rd` clears them and the UART-side request, but leaves `irq_stat[1]` unchanged.
- R10: Status bit 1 is cleared only by writing 1 to it. `rx_irq` is the OR of both status bits and the UART-side request, so it falls only after every flag is cleared.
- R11: With error interrupts disabled, line errors still show in `lsr_data` but set neither `irq_stat[1]` nor `rx_irq`.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load configuration, base and count |
| cfg_ctl | input | 5 | Enable, direction, size code, error-interrupt enable |
| cfg_base | input | AW | Start address |
| cfg_count | input | CW | Number of memory writes |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Line errors of this character |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_data | output | 3 | Sticky line-error flags |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Write-1-to-clear mask |
| irq_stat | output | 2 | Completion and line-error status |
| rx_irq | output | 1 | Receive interrupt |
| dma_active | output | 1 | Transfer in progress |
| mem_we | output | 1 | Memory write pulse |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Packed write data |

## Verification
The packing path is run in all three legal sizes with distinct byte values. A wrong lane order, a wrong address step or a wrong write cadence therefore each give a different mismatch. The reserved code, a cleared direction bit and a zero count are tried, to separate correct start gating from a start that merely looks idle. Line errors are injected during an active transfer and while the engine is idle, with error interrupts on and off. The two clears are applied in both orders, which exposes an interrupt that drops after only one of them.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int NB_W = 3;

  typedef struct packed {
    logic       err_ie;
    logic [1:0] size;
    logic       dir;
    logic       en;
  } rx_cfg_t;

  localparam logic [1:0] SZ_HALF = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_RSVD = 2'b10;
  localparam logic [1:0] SZ_BYTE = 2'b11;

  // bytes per memory write; zero marks an illegal code
  function automatic logic [NB_W-1:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_HALF: size_bytes = NB_W'(2);
      SZ_WORD: size_bytes = NB_W'(4);
      SZ_BYTE: size_bytes = NB_W'(1);
      default: size_bytes = '0;
    endcase
  endfunction
endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer
  import rxdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            byte_vld,
  input  logic [7:0]      byte_in,
  input  logic [NB_W-1:0] nbytes,
  output logic            word_vld,
  output logic [DW-1:0]   word
);
  localparam int LANES = DW / 8;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] acc_q, acc_d;

  always_comb begin
    word = acc_q;
    for (int i = 0; i < LANES; i++) begin
      if (idx_q == IW'(i)) word[i*8 +: 8] = byte_in;
    end
    word_vld = byte_vld && ((NB_W'(idx_q) + NB_W'(1)) == nbytes);
  end

  always_comb begin
    idx_d = idx_q;
    acc_d = acc_q;
    if (clear) begin
      idx_d = '0;
      acc_d = '0;
    end else if (byte_vld) begin
      if (word_vld) begin
        idx_d = '0;
        acc_d = '0;
      end else begin
        idx_d = idx_q + IW'(1);
        acc_d = word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (clear || byte_vld) begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
  end

  // R1: the lane being filled never passes the configured size
  a_r1_lane_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (NB_W'(idx_q) < nbytes));
endmodule

// File: rtl/rxdma_xfer.sv
module rxdma_xfer
  import rxdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            start_req,
  input  logic [1:0]      new_size,
  input  logic [1:0]      cur_size,
  input  logic [AW-1:0]   base,
  input  logic [CW-1:0]   count,
  input  logic            word_vld,
  input  logic [DW-1:0]   word,
  output logic [NB_W-1:0] nbytes,
  output logic            active,
  output logic            done_evt,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  logic          act_q, act_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          we_q, we_d;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q;
  logic          start_ok;

  assign nbytes   = size_bytes(cur_size);
  assign start_ok = start_req && (size_bytes(new_size) != '0) && (count != '0);

  always_comb begin
    act_d    = act_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    we_d     = 1'b0;
    done_evt = 1'b0;
    if (cfg_load) begin
      act_d  = start_ok;
      addr_d = base;
      rem_d  = count;
    end else if (act_q && word_vld) begin
      we_d   = 1'b1;
      addr_d = addr_q + AW'(nbytes);
      rem_d  = rem_q - CW'(1);
      if (rem_q == CW'(1)) begin
        act_d    = 1'b0;
        done_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      we_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      we_q   <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      waddr_q <= addr_q;
      wdata_q <= word;
    end
  end

  assign active    = act_q;
  assign mem_we    = we_q;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wdata_q;

  // R4: an active transfer always has a legal size
  a_r4_active_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (nbytes != '0));
  // R5: a write is only issued while a transfer was running
  a_r5_write_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(act_q));
endmodule

// File: rtl/rxdma_irq.sv
module rxdma_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_ie,
  input  logic       rx_valid,
  input  logic [2:0] rx_err,
  input  logic       lsr_rd,
  input  logic       stat_wr,
  input  logic [1:0] stat_wdata,
  input  logic       done_evt,
  output logic [2:0] lsr_data,
  output logic [1:0] irq_stat,
  output logic       rx_irq
);
  logic [2:0] uerr_q, uerr_d;
  logic       ureq_q, ureq_d;
  logic       done_q, done_d;
  logic       derr_q, derr_d;
  logic       err_set;

  always_comb begin
    err_set = rx_valid && (rx_err != 3'b000);
    uerr_d  = (lsr_rd ? 3'b000 : uerr_q) | (rx_valid ? rx_err : 3'b000);
    ureq_d  = (ureq_q && !lsr_rd) || (err_set && err_ie);
    done_d  = (done_q && !(stat_wr && stat_wdata[0])) || done_evt;
    derr_d  = (derr_q && !(stat_wr && stat_wdata[1])) || (err_set && err_ie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uerr_q <= '0;
      ureq_q <= 1'b0;
      done_q <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      uerr_q <= uerr_d;
      ureq_q <= ureq_d;
      done_q <= done_d;
      derr_q <= derr_d;
    end
  end

  assign lsr_data = uerr_q;
  assign irq_stat = {derr_q, done_q};
  assign rx_irq   = done_q | derr_q | ureq_q;

  // R11: the engine-side error bit only rises with error interrupts enabled
  a_r11_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(derr_q) |-> $past(err_ie));
  // R10: a write of 1 to bit 1 without a new error clears it
  a_r10_w1c_err: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[1] && !err_set) |=> !derr_q);
  // R9: a line-status read without a new error drops the UART-side flags
  a_r9_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid) |=> (lsr_data == 3'b000));
endmodule

// File: rtl/uart_rxdma_ctrl.sv
module uart_rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [4:0]    cfg_ctl,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [2:0]    rx_err,
  input  logic          lsr_rd,
  output logic [2:0]    lsr_data,
  input  logic          stat_wr,
  input  logic [1:0]    stat_wdata,
  output logic [1:0]    irq_stat,
  output logic          rx_irq,
  output logic          dma_active,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic [1:0]      rst_pipe;
  logic            rst_s_n;
  rx_cfg_t         cfg_new;
  logic            ie_q, ie_d;
  logic [1:0]      sz_q, sz_d;
  logic            byte_vld;
  logic            word_vld;
  logic [DW-1:0]   word;
  logic [NB_W-1:0] nbytes;
  logic            done_evt;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign cfg_new = rx_cfg_t'(cfg_ctl);

  always_comb begin
    ie_d = cfg_wr ? cfg_new.err_ie : ie_q;
    sz_d = cfg_wr ? cfg_new.size   : sz_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ie_q <= 1'b0;
      sz_q <= SZ_RSVD;
    end else if (cfg_wr) begin
      ie_q <= ie_d;
      sz_q <= sz_d;
    end
  end

  assign byte_vld = rx_valid && dma_active && !cfg_wr;

  rxdma_packer #(.DW(DW)) u_pack (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clear    (cfg_wr),
    .byte_vld (byte_vld),
    .byte_in  (rx_data),
    .nbytes   (nbytes),
    .word_vld (word_vld),
    .word     (word)
  );

  rxdma_xfer #(.AW(AW), .CW(CW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cfg_load  (cfg_wr),
    .start_req (cfg_new.en && cfg_new.dir),
    .new_size  (cfg_new.size),
    .cur_size  (sz_q),
    .base      (cfg_base),
    .count     (cfg_count),
    .word_vld  (word_vld),
    .word      (word),
    .nbytes    (nbytes),
    .active    (dma_active),
    .done_evt  (done_evt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  rxdma_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .err_ie     (ie_q),
    .rx_valid   (rx_valid),
    .rx_err     (rx_err),
    .lsr_rd     (lsr_rd),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .done_evt   (done_evt),
    .lsr_data   (lsr_data),
    .irq_stat   (irq_stat),
    .rx_irq     (rx_irq)
  );

  // R2: every write follows a received character by one clock
  a_r2_write_after_byte: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> $past(rx_valid));
  // R5: completion appears together with the final write
  a_r5_done_with_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_stat[0]) |-> mem_we);
  // R10: the interrupt only falls after a software clear
  a_r10_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(rx_irq) |-> $past(lsr_rd || stat_wr));
endmodule

// File: tb/sim_uart_rxdma_ctrl.sv
`timescale 1ns/1ps
module sim_uart_rxdma_ctrl;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [4:0]    cfg_ctl;
  logic [AW-1:0] cfg_base;
  logic [CW-1:0] cfg_count;
  logic          rx_valid;
  logic [7:0]    rx_data;
  logic [2:0]    rx_err;
  logic          lsr_rd;
  logic [2:0]    lsr_data;
  logic          stat_wr;
  logic [1:0]    stat_wdata;
  logic [1:0]    irq_stat;
  logic          rx_irq;
  logic          dma_active;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rxdma_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u0 (.*);

  // ---------------- reference model ----------------
  logic [7:0]    q[$];
  bit            m_active, m_we, m_done, m_derr, m_ureq, m_ie;
  logic [1:0]    m_sz;
  logic [2:0]    m_uerr;
  logic [AW-1:0] m_addr, m_waddr;
  logic [DW-1:0] m_wdata;
  int            m_rem;
  int            nwrites = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  function automatic int bytes_of(input logic [1:0] c);
    case (c)
      2'b11: return 1;
      2'b00: return 2;
      2'b01: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_active = 0; m_we = 0; m_done = 0; m_derr = 0; m_ureq = 0; m_ie = 0;
      m_sz = 2'b10; m_uerr = 0; m_addr = 0; m_waddr = 0; m_wdata = 0; m_rem = 0;
    end else begin
      m_we = 0;
      if (lsr_rd) begin m_uerr = 0; m_ureq = 0; end
      if (stat_wr && stat_wdata[0]) m_done = 0;
      if (stat_wr && stat_wdata[1]) m_derr = 0;
      if (rx_valid && rx_err != 0) begin
        m_uerr |= rx_err;
        if (m_ie) begin m_ureq = 1; m_derr = 1; end
      end
      if (cfg_wr) begin
        m_ie = cfg_ctl[4];
        m_sz = cfg_ctl[3:2];
        m_active = cfg_ctl[0] && cfg_ctl[1] && bytes_of(cfg_ctl[3:2]) != 0 && cfg_count != 0;
        m_addr = cfg_base;
        m_rem = int'(cfg_count);
        q.delete();
      end else if (rx_valid && m_active) begin
        q.push_back(rx_data);
        if (q.size() == bytes_of(m_sz)) begin
          logic [DW-1:0] w;
          w = '0;
          for (int i = 0; i < q.size(); i++) w[i*8 +: 8] = q[i];
          m_we = 1; m_waddr = m_addr; m_wdata = w;
          m_addr += AW'(bytes_of(m_sz));
          m_rem--;
          if (m_rem == 0) begin m_active = 0; m_done = 1; end
          q.delete();
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(mem_we == m_we, "R2 mem_we", 64'(mem_we), 64'(m_we));
      if (mem_we && m_we) begin
        check(mem_addr == m_waddr, "R1 mem_addr", 64'(mem_addr), 64'(m_waddr));
        check(mem_wdata == m_wdata, "R1 mem_wdata", 64'(mem_wdata), 64'(m_wdata));
      end
      if (mem_we) begin nwrites++; last_addr = mem_addr; last_data = mem_wdata; end
      check(dma_active == m_active, "R3 dma_active", 64'(dma_active), 64'(m_active));
      check(irq_stat == {m_derr, m_done}, "R6 irq_stat", 64'(irq_stat), 64'({m_derr, m_done}));
      check(rx_irq == (m_done | m_derr | m_ureq), "R10 rx_irq", 64'(rx_irq), 64'(m_done | m_derr | m_ureq));
      check(lsr_data == m_uerr, "R9 lsr_data", 64'(lsr_data), 64'(m_uerr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfg(input logic [4:0] ctl, input logic [AW-1:0] base, input logic [CW-1:0] cnt);
    cfg_wr = 1; cfg_ctl = ctl; cfg_base = base; cfg_count = cnt;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rxb(input logic [7:0] d, input logic [2:0] e);
    rx_valid = 1; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
  endtask

  task automatic lsr_read();
    lsr_rd = 1;
    @(negedge clk);
    lsr_rd = 0;
  endtask

  task automatic w1c(input logic [1:0] m);
    stat_wr = 1; stat_wdata = m;
    @(negedge clk);
    stat_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    rst_n = 0; cfg_wr = 0; cfg_ctl = 0; cfg_base = 0; cfg_count = 0;
    rx_valid = 0; rx_data = 0; rx_err = 0; lsr_rd = 0; stat_wr = 0; stat_wdata = 0;
    idle(3);
    // R12: reset state
    check({mem_we, dma_active, rx_irq, irq_stat, lsr_data} == 0, "R12 reset outputs",
          64'({mem_we, dma_active, rx_irq, irq_stat, lsr_data}), 0);
    @(negedge clk); rst_n = 1;
    idle(4);

    // R1/R5: byte size, three writes
    do_cfg(5'b01111, 32'h100, 3);
    rxb(8'h11, 0); rxb(8'h22, 0); rxb(8'h33, 0);
    idle(2);
    check(nwrites == 3, "R1 byte writes", 64'(nwrites), 3);
    check(last_addr == 32'h102 && last_data == 32'h33, "R1 byte last", 64'(last_addr), 64'h102);
    check(dma_active == 0 && irq_stat == 2'b01, "R5 done", 64'({dma_active, irq_stat}), 64'h1);
    rxb(8'h44, 0); idle(2);
    check(nwrites == 3, "R5 ignored after done", 64'(nwrites), 3);
    // R6: write-1-to-clear
    w1c(2'b00); idle(1);
    check(irq_stat[0] == 1, "R6 write 0 no effect", 64'(irq_stat), 1);
    w1c(2'b01); idle(1);
    check(irq_stat == 0 && rx_irq == 0, "R6 clear done", 64'({rx_irq, irq_stat}), 0);

    // R1: half words
    do_cfg(5'b00011, 32'h200, 2);
    rxb(8'h01, 0); rxb(8'h02, 0); rxb(8'h03, 0); rxb(8'h04, 0);
    idle(2);
    check(last_addr == 32'h202 && last_data == 32'h0403, "R1 half word", 64'(last_data), 64'h0403);
    w1c(2'b01);

    // R1/R2: words
    n0 = nwrites;
    do_cfg(5'b00111, 32'h300, 1);
    rxb(8'hA1, 0); rxb(8'hB2, 0); rxb(8'hC3, 0);
    idle(1);
    check(nwrites == n0, "R2 no write before fourth byte", 64'(nwrites), 64'(n0));
    rxb(8'hD4, 0); idle(2);
    check(last_addr == 32'h300 && last_data == 32'hD4C3B2A1, "R1 word", 64'(last_data), 64'hD4C3B2A1);
    w1c(2'b01);

    // R4: reserved size
    n0 = nwrites;
    do_cfg(5'b01011, 32'h500, 4);
    idle(1);
    check(dma_active == 0, "R4 reserved no start", 64'(dma_active), 0);
    rxb(8'h55, 0); rxb(8'h66, 0); idle(2);
    check(nwrites == n0, "R4 reserved no write", 64'(nwrites), 64'(n0));

    // R3: direction clear, zero count
    do_cfg(5'b01101, 32'h600, 4); idle(1);
    check(dma_active == 0, "R3 direction clear", 64'(dma_active), 0);
    do_cfg(5'b01111, 32'h600, 0); idle(1);
    check(dma_active == 0, "R3 zero count", 64'(dma_active), 0);
    rxb(8'h77, 0); idle(2);
    check(nwrites == n0, "R3 no write", 64'(nwrites), 64'(n0));

    // R7/R8/R9/R10: parity error mid-transfer, UART side cleared first
    do_cfg(5'b10111, 32'h400, 1);
    rxb(8'h10, 0); rxb(8'h20, 3'b010); idle(1);
    check(irq_stat[1] == 1 && rx_irq == 1, "R7 error interrupt", 64'({rx_irq, irq_stat}), 64'h6);
    check(dma_active == 1, "R8 transfer continues", 64'(dma_active), 1);
    rxb(8'h30, 0); rxb(8'h40, 0); idle(2);
    check(last_data == 32'h40302010, "R8 error byte stored", 64'(last_data), 64'h40302010);
    check(lsr_data == 3'b010, "R9 parity flag", 64'(lsr_data), 2);
    w1c(2'b01); idle(1);
    check(rx_irq == 1, "R10 irq after done clear", 64'(rx_irq), 1);
    lsr_read(); idle(1);
    check(lsr_data == 0 && irq_stat[1] == 1 && rx_irq == 1, "R9 lsr read keeps status",
          64'({rx_irq, irq_stat, lsr_data}), 64'h30);
    w1c(2'b00); idle(1);
    check(irq_stat[1] == 1, "R10 write 0 no effect", 64'(irq_stat), 2);
    w1c(2'b10); idle(1);
    check(rx_irq == 0, "R10 irq drops after both", 64'(rx_irq), 0);

    // R10: framing error while idle, engine side cleared first
    do_cfg(5'b10000, 32'h0, 0);
    rxb(8'h99, 3'b100); idle(1);
    check(irq_stat == 2'b10 && rx_irq == 1, "R7 idle error", 64'({rx_irq, irq_stat}), 64'h6);
    w1c(2'b10); idle(1);
    check(irq_stat == 0 && rx_irq == 1, "R10 UART request holds irq", 64'({rx_irq, irq_stat}), 64'h4);
    lsr_read(); idle(1);
    check(rx_irq == 0, "R10 irq drops after lsr read", 64'(rx_irq), 0);

    // R11: error interrupts disabled
    do_cfg(5'b00000, 32'h0, 0);
    rxb(8'h5A, 3'b001); idle(1);
    check(lsr_data == 3'b001, "R11 flag latched", 64'(lsr_data), 1);
    check(irq_stat == 0 && rx_irq == 0, "R11 no interrupt", 64'({rx_irq, irq_stat}), 0);
    lsr_read(); idle(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule